// File: doc/BRIEF.md
# PCI Target Back-End Address Decoder and Register Bank

This block sits on the user side of a PCI target core. The core announces each target access with a one-cycle address strobe. In that cycle the shared 32-bit bus holds the target address and the 4-bit command bus holds the PCI command. In that same cycle the block compares the address against a 4 KB memory window and classifies the command. It raises a read-decode or write-decode flag straight back to the core, with no register in the path.

The core shows the address only once per burst. The block therefore latches it and keeps its own beat counter. For writes, every increment strobe carries a data word. That word is stored into a byte-addressable register bank whether or not the back-end is ready. For reads, a beat completes only when the increment strobe and the back-end ready are high together. The read data for the current beat address is always waiting on the read-data output.

Top module: `pci_tgt_backend`

## Requirements
- R1: While `rst` is high at a clock edge, the beat address is cleared to zero and the transfer type returns to idle. After reset, increment strobes change neither the beat address nor the register bank until a decoded address phase occurs.
- R2: With `adr_valid` high and the address inside the window [BASE_ADDR, BASE_ADDR+4096), `rd_decode` is high in that same cycle for the read commands 4'b0010, 4'b0110, 4'b1100 and 4'b1110, and low for every other command.
- R3: With `adr_valid` high and the address inside the window, `wr_decode` is high in that same cycle for the write commands 4'b0011 and 4'b0111, and low for every other command.
- R4: An address outside the window, or a command that is neither a listed read nor a listed write, gives no decode flag. The increment strobes of that access neither advance the beat address nor write the register bank.
- R5: Both decode flags are low in every cycle in which `adr_valid` is low, and they are never high together.
- R6: One cycle after an address phase, `beat_addr` equals the address presented with `adr_valid`.
- R7: During a decoded write, each cycle with `adr_inc` high stores the word on `usr_ad` and advances `beat_addr` by 4, whatever the level of `bk_ready`.
- R8: On a write beat, `usr_cbe` carries active-low byte enables. Byte lane k (bits 8k+7..8k) is written only when bit k is 0; the other lanes keep their old contents.
- R9: During a decoded read, `beat_addr` advances by 4 only in a cycle in which `adr_inc` and `bk_ready` are both high. Otherwise it holds.
- R10: From the cycle after an address phase or a read advance, `rd_data` holds the bank word indexed by `beat_addr` bits [11:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usr_ad | input | 32 | Address in the address phase, write data during write beats |
| usr_cbe | input | 4 | PCI command in the address phase, active-low byte enables during beats |
| adr_valid | input | 1 | Address phase strobe from the core |
| adr_inc | input | 1 | Beat strobe from the core |
| bk_ready | input | 1 | Back-end ready; qualifies read beats only |
| rd_decode | output | 1 | Decoded read to this window, same cycle as `adr_valid` |
| wr_decode | output | 1 | Decoded write to this window, same cycle as `adr_valid` |
| beat_addr | output | 32 | Current local beat address |
| rd_data | output | 32 | Bank word at the current beat address |

## Verification
Suppose the beat counter or the transfer type is wrong inside the block. One cycle after the faulty beat, `beat_addr` shows a missing, extra or misplaced step of 4. A wrong write index or byte mask stays hidden until a later read burst visits that word. It then shows on `rd_data` in the cycle after the address phase or the read advance that reaches it. A wrong decode shows at once, in the address-phase cycle itself.

// File: rtl/pcitb_pkg.sv
package pcitb_pkg;

  typedef enum logic [3:0] {
    CMD_IO_RD       = 4'b0010,
    CMD_IO_WR       = 4'b0011,
    CMD_MEM_RD      = 4'b0110,
    CMD_MEM_WR      = 4'b0111,
    CMD_MEM_RD_MULT = 4'b1100,
    CMD_MEM_RD_LINE = 4'b1110
  } pci_cmd_e;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'b00,
    XF_READ  = 2'b01,
    XF_WRITE = 2'b10
  } xfer_e;

  function automatic logic is_read_cmd(input logic [3:0] c);
    case (c)
      CMD_IO_RD, CMD_MEM_RD, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE: is_read_cmd = 1'b1;
      default: is_read_cmd = 1'b0;
    endcase
  endfunction

  function automatic logic is_write_cmd(input logic [3:0] c);
    case (c)
      CMD_IO_WR, CMD_MEM_WR: is_write_cmd = 1'b1;
      default: is_write_cmd = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tgt_cmd_decode.sv
module tgt_cmd_decode
  import pcitb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_BITS = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  input  logic              valid,
  output logic              hit_rd,
  output logic              hit_wr
);
  localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_BITS;

  logic in_win;

  always_comb begin
    in_win = ((addr ^ BASE_ADDR) & WIN_MASK) == '0;
    hit_rd = valid & in_win & is_read_cmd(cmd);
    hit_wr = valid & in_win & is_write_cmd(cmd);
  end
endmodule

// File: rtl/tgt_beat_ctr.sv
module tgt_beat_ctr
  import pcitb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_BITS = 12,
  parameter int BEAT_BYTES = 4,
  localparam int IDX_W = WIN_BITS - $clog2(BEAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adr_valid,
  input  logic [ADDR_W-1:0] adr_in,
  input  logic              adr_inc,
  input  logic              bk_ready,
  input  logic              start_rd,
  input  logic              start_wr,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              wr_beat,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx
);
  localparam int LSB = $clog2(BEAT_BYTES);

  xfer_e             st;
  logic [ADDR_W-1:0] cnt, cnt_nx;
  logic              advance;

  always_comb begin
    wr_beat = !adr_valid && (st == XF_WRITE) && adr_inc;
    advance = wr_beat || (!adr_valid && (st == XF_READ) && adr_inc && bk_ready);
    if (adr_valid)    cnt_nx = adr_in;
    else if (advance) cnt_nx = cnt + ADDR_W'(BEAT_BYTES);
    else              cnt_nx = cnt;
    rd_idx = cnt_nx[WIN_BITS-1:LSB];
    wr_idx = cnt[WIN_BITS-1:LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      st  <= XF_IDLE;
    end else begin
      cnt <= cnt_nx;
      if (adr_valid)
        st <= start_rd ? XF_READ : (start_wr ? XF_WRITE : XF_IDLE);
    end
  end

  assign beat_addr = cnt;

  // R1: reset clears the counter and the transfer type
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0 && st == XF_IDLE));

  a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
    st != 2'b11);

  // R7: a write beat steps by one word even without ready
  a_r7_write_step: assert property (@(posedge clk) disable iff (rst)
    (!adr_valid && st == XF_WRITE && adr_inc) |=> cnt == $past(cnt) + ADDR_W'(BEAT_BYTES));

  // R9: a read beat without back-end ready holds the counter
  a_r9_read_stall: assert property (@(posedge clk) disable iff (rst)
    (!adr_valid && st == XF_READ && !(adr_inc && bk_ready)) |=> $stable(cnt));

  // R4: no transfer type means no movement
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!adr_valid && st == XF_IDLE) |=> $stable(cnt));
endmodule

// File: rtl/tgt_regbank.sv
module tgt_regbank #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 10,
  localparam int LANES = DATA_W / 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we && !be_n[g]) mem[wr_idx] <= wdata[g*8 +: 8];
      q <= mem[rd_idx];
    end

    assign rd_data[g*8 +: 8] = q;
  end
endmodule

// File: rtl/pci_tgt_backend.sv
module pci_tgt_backend #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_BITS = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = WIN_BITS - $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] usr_ad,
  input  logic [LANES-1:0]  usr_cbe,
  input  logic              adr_valid,
  input  logic              adr_inc,
  input  logic              bk_ready,
  output logic              rd_decode,
  output logic              wr_decode,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic             wr_beat;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  tgt_cmd_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(usr_ad), .cmd(usr_cbe), .valid(adr_valid),
    .hit_rd(rd_decode), .hit_wr(wr_decode)
  );

  tgt_beat_ctr #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BEAT_BYTES(LANES)) u_ctr (
    .clk(clk), .rst(rst), .adr_valid(adr_valid), .adr_in(usr_ad),
    .adr_inc(adr_inc), .bk_ready(bk_ready),
    .start_rd(rd_decode), .start_wr(wr_decode),
    .beat_addr(beat_addr), .wr_beat(wr_beat), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  tgt_regbank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .we(wr_beat), .wr_idx(wr_idx), .wdata(usr_ad),
    .be_n(usr_cbe), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // R5: decode flags only in the address phase, never both
  a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_decode || wr_decode) |-> adr_valid);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_decode && wr_decode));

  // R6: the address is latched in the address phase
  a_r6_latch: assert property (@(posedge clk) disable iff (rst)
    adr_valid |=> beat_addr == $past(usr_ad));
endmodule

// File: tb/sim_pci_tgt_backend.sv
module sim_pci_tgt_backend;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 0, rst = 1;
  logic [31:0] usr_ad = '0;
  logic [3:0] usr_cbe = '0;
  logic adr_valid = 0, adr_inc = 0, bk_ready = 0;
  logic rd_decode, wr_decode;
  logic [31:0] beat_addr, rd_data;

  int total = 0, bad = 0;
  logic [31:0] model [1024];

  always #5 clk = ~clk;

  pci_tgt_backend u0 (
    .clk(clk), .rst(rst), .usr_ad(usr_ad), .usr_cbe(usr_cbe),
    .adr_valid(adr_valid), .adr_inc(adr_inc), .bk_ready(bk_ready),
    .rd_decode(rd_decode), .wr_decode(wr_decode),
    .beat_addr(beat_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_rd(input logic [3:0] c);
    return c == 4'b0010 || c == 4'b0110 || c == 4'b1100 || c == 4'b1110;
  endfunction

  function automatic logic exp_wr(input logic [3:0] c);
    return c == 4'b0011 || c == 4'b0111;
  endfunction

  // one address phase; decode flags are checked in the phase itself
  task automatic addr_phase(input logic [3:0] cmd, input logic [31:0] a,
                            input logic erd, input logic ewr);
    @(negedge clk);
    adr_valid = 1; usr_ad = a; usr_cbe = cmd; adr_inc = 0;
    #1;
    check("R2 rd_decode", {31'd0, rd_decode}, {31'd0, erd});
    check("R3 wr_decode", {31'd0, wr_decode}, {31'd0, ewr});
    @(negedge clk);
    adr_valid = 0; usr_ad = '0; usr_cbe = '0;
    #1;
    check("R6 latched address", beat_addr, a);
    check("R5 flags low after phase", {30'd0, rd_decode, wr_decode}, 32'd0);
  endtask

  task automatic write_beat(input logic [31:0] d, input logic [3:0] be_n, input logic rdy);
    @(negedge clk);
    adr_inc = 1; usr_ad = d; usr_cbe = be_n; bk_ready = rdy;
    @(negedge clk);
    adr_inc = 0; usr_ad = '0; usr_cbe = '0; bk_ready = 0;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 beat_addr after reset", beat_addr, 32'd0);
    check("R5 flags idle in reset", {30'd0, rd_decode, wr_decode}, 32'd0);
    rst = 0;
    write_beat(32'hDEAD_BEEF, 4'b0000, 1'b1);
    #1;
    check("R1 no step before address phase", beat_addr, 32'd0);
  endtask

  task automatic t_decode;
    for (int c = 0; c < 16; c++)
      addr_phase(4'(c), BASE + 32'h40, exp_rd(4'(c)), exp_wr(4'(c)));
    addr_phase(4'b0110, BASE + 32'hFFC, 1'b1, 1'b0);
    addr_phase(4'b0110, BASE + 32'h1000, 1'b0, 1'b0);
    addr_phase(4'b0111, BASE - 32'h4, 1'b0, 1'b0);
  endtask

  task automatic t_write_burst;
    logic [31:0] a;
    a = BASE + 32'h10;
    addr_phase(4'b0111, a, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      write_beat(32'h1111_0000 + 32'(i) * 32'h0101_0101, 4'b0000, 1'(i % 2));
      model[4 + i] = 32'h1111_0000 + 32'(i) * 32'h0101_0101;
      #1;
      check("R7 write step ignores ready", beat_addr, a + 32'(4 * (i + 1)));
    end
    addr_phase(4'b0011, a + 32'h4, 1'b0, 1'b1);
    write_beat(32'hAABB_CCDD, 4'b1010, 1'b0);
    model[5] = {model[5][31:24], 8'hBB, model[5][15:8], 8'hDD};
    #1;
    check("R8 partial beat steps", beat_addr, a + 32'h8);
  endtask

  task automatic t_ignored;
    addr_phase(4'b1011, BASE + 32'h14, 1'b0, 1'b0);
    write_beat(32'h5555_5555, 4'b0000, 1'b1);
    #1;
    check("R4 unknown command holds address", beat_addr, BASE + 32'h14);
    addr_phase(4'b0111, BASE + 32'h1014, 1'b0, 1'b0);
    write_beat(32'h6666_6666, 4'b0000, 1'b1);
    #1;
    check("R4 out of window holds address", beat_addr, BASE + 32'h1014);
  endtask

  task automatic t_read_burst;
    logic [31:0] a;
    a = BASE + 32'h10;
    addr_phase(4'b1100, a, 1'b1, 1'b0);
    check("R10 first word", rd_data, model[4]);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      adr_inc = 1; bk_ready = 0;
      @(negedge clk);
      #1;
      check("R9 hold without ready", beat_addr, a + 32'(4 * i));
      check("R10 data held on stall", rd_data, model[4 + i]);
      adr_inc = 0; bk_ready = 1;
      @(negedge clk);
      #1;
      check("R9 hold without inc", beat_addr, a + 32'(4 * i));
      adr_inc = 1; bk_ready = 1;
      @(negedge clk);
      adr_inc = 0; bk_ready = 0;
      #1;
      check("R9 step on inc and ready", beat_addr, a + 32'(4 * (i + 1)));
      if (i < 3) check("R10 next word", rd_data, model[5 + i]);
    end
    addr_phase(4'b0010, BASE + 32'h14, 1'b1, 1'b0);
    check("R8 R4 merged word intact", rd_data, model[5]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_decode;
    t_write_burst;
    t_ignored;
    t_read_burst;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule